// File: doc/BRIEF.md
# Flag-Setting Data-Processing ALU

This block carries out one integer data-processing operation per clock cycle on a 32-bit register operand and a second operand that a shifter upstream has already prepared. A 4-bit operation code selects one of sixteen operations. These cover add, subtract and reverse subtract, each with and without a carry input, plus bitwise logic, moves, and four compare/test operations. The arithmetic and logical paths are combinational. The result and the destination write strobe are valid in the same cycle as the inputs.

A small status register holds the negative, zero, carry and overflow flags. The chained arithmetic operations read its carry bit. The register loads new values on the rising clock edge, but only when an update is enabled. Compare/test operations always update the flags and never request a destination write. All other operations update the flags only when the set-flags input is high. The combinational next-flag value is also available as an output, so a pipeline can forward it.

Top module: `dp_alu`

## Requirements
- R1: Operation code 4 (ADD) gives rn+n, and code 5 (ADC) gives rn+n+C, where C is the stored carry flag; the sum is taken modulo 2^32.
- R2: Code 2 (SUB) gives rn-n, and code 6 (SBC) gives rn-n-(1-C), so a stored carry of 0 acts as a borrow.
- R3: Code 3 (RSB) gives n-rn, and code 7 (RSC) gives n-rn-(1-C).
- R4: Code 0 gives rn&n, code 1 gives rn^n, code 12 gives rn|n, and code 14 gives rn&~n.
- R5: Code 13 (MOV) outputs n and code 15 (MVN) outputs ~n; for both, the value of rn has no effect on the result.
- R6: Codes 8 (TST, rn&n), 9 (TEQ, rn^n), 10 (CMP, rn-n) and 11 (CMN, rn+n) hold wr_en_o low and update the flags even when set_flags_i is 0; result_o still shows the computed value. All other codes drive wr_en_o high.
- R7: The flag register loads only on a clock edge where the update is enabled. For codes other than 8 to 11, the update is enabled only when set_flags_i is 1; otherwise flags_o holds, and flags_next_o equals flags_o.
- R8: On an update, N becomes bit 31 of the computed value, and Z becomes 1 exactly when that value is zero.
- R9: On an update by an arithmetic code (2 to 7, 10, 11), C becomes the adder carry-out (for subtraction, 1 means no borrow), and V becomes the signed overflow of the operation.
- R10: On an update by a logical or move code (0, 1, 8, 9, 12 to 15), C becomes shift_carry_i and V keeps its previous value.
- R11: While rst_n is low, all four flags are 0. The flag order on flags_o and flags_next_o is {N,Z,C,V}, with N at bit 3 and V at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| rn_i | input | 32 | First operand (register) |
| n_i | input | 32 | Second operand, already shifted |
| set_flags_i | input | 1 | Request a flag update for non-compare operations |
| shift_carry_i | input | 1 | Carry-out of the upstream shifter |
| result_o | output | 32 | Computed value |
| wr_en_o | output | 1 | Destination write enable |
| flags_o | output | 4 | Stored flags {N,Z,C,V} |
| flags_next_o | output | 4 | Value the flag register takes at the next edge |

## Verification
The bench runs the carry-chained operations with the stored carry both set and clear. A design that used the carry directly as a borrow, instead of its inverse, gives results that are off by one.

It forces a signed overflow on both an add and a compare-negative. This catches a missing or wrongly signed V term, and a logical operation that clears V instead of keeping it.

Compare/test codes are issued with set_flags_i low. A decoder that treated them like ordinary operations would either leave the flags untouched or raise a write. Ordinary operations are also issued with set_flags_i low, and the flags must not move.

Moves are repeated with different first operands, and reset is asserted mid-run. These catch a move that leaks rn into its result and a flag register that does not clear.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  function automatic logic op_is_cmp(alu_op_e op);
    return (op == OP_TST) || (op == OP_TEQ) || (op == OP_CMP) || (op == OP_CMN);
  endfunction

  function automatic logic op_is_arith(alu_op_e op);
    case (op)
      OP_SUB, OP_RSB, OP_ADD, OP_ADC,
      OP_SBC, OP_RSC, OP_CMP, OP_CMN: return 1'b1;
      default:                        return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dp_alu_core.sv
module dp_alu_core
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] rn,
  input  logic [WIDTH-1:0] n,
  input  logic             c_in,
  output logic [WIDTH-1:0] res,
  output logic             is_arith,
  output logic             carry,
  output logic             ovf
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] add_a;
  logic [WIDTH-1:0] add_b;
  logic             add_cin;
  logic [WIDTH:0]   sum;
  logic [WIDTH-1:0] logic_res;

  // Operand steering: subtraction is a + ~b + 1, borrow-chained forms
  // replace the +1 with the stored carry.
  always_comb begin
    add_a   = rn;
    add_b   = n;
    add_cin = 1'b0;
    case (op)
      OP_ADD, OP_CMN: begin add_a = rn; add_b = n;  add_cin = 1'b0; end
      OP_ADC:         begin add_a = rn; add_b = n;  add_cin = c_in; end
      OP_SUB, OP_CMP: begin add_a = rn; add_b = ~n; add_cin = 1'b1; end
      OP_SBC:         begin add_a = rn; add_b = ~n; add_cin = c_in; end
      OP_RSB:         begin add_a = n;  add_b = ~rn; add_cin = 1'b1; end
      OP_RSC:         begin add_a = n;  add_b = ~rn; add_cin = c_in; end
      default:        begin add_a = rn; add_b = n;  add_cin = 1'b0; end
    endcase
  end

  assign sum = {1'b0, add_a} + {1'b0, add_b} + {{WIDTH{1'b0}}, add_cin};

  always_comb begin
    case (op)
      OP_AND, OP_TST: logic_res = rn & n;
      OP_EOR, OP_TEQ: logic_res = rn ^ n;
      OP_ORR:         logic_res = rn | n;
      OP_BIC:         logic_res = rn & ~n;
      OP_MOV:         logic_res = n;
      OP_MVN:         logic_res = ~n;
      default:        logic_res = '0;
    endcase
  end

  assign is_arith = op_is_arith(op);
  assign res      = is_arith ? sum[MSB:0] : logic_res;
  assign carry    = sum[WIDTH];
  assign ovf      = (add_a[MSB] == add_b[MSB]) && (sum[MSB] != add_a[MSB]);

endmodule

// File: rtl/dp_alu_flags.sv
module dp_alu_flags
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  alu_op_e          op,
  input  logic             set_flags,
  input  logic             shift_c,
  input  logic [WIDTH-1:0] res,
  input  logic             is_arith,
  input  logic             carry,
  input  logic             ovf,
  output flags_t           flags_q,
  output flags_t           flags_d,
  output logic             upd
);

  flags_t computed;

  assign upd = set_flags || op_is_cmp(op);

  always_comb begin
    computed.n = res[WIDTH-1];
    computed.z = (res == '0);
    computed.c = is_arith ? carry : shift_c;
    computed.v = is_arith ? ovf : flags_q.v;
  end

  always_comb begin
    flags_d = flags_q;
    if (upd) flags_d = computed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else if (upd) flags_q <= flags_d;
  end

  // R7
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(flags_q));

  // R8
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (flags_q.z == ($past(res) == '0)) && (flags_q.n == $past(res[WIDTH-1])));

  // R10
  logic_cv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !is_arith) |=> (flags_q.v == $past(flags_q.v)) && (flags_q.c == $past(shift_c)));

endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] rn_i,
  input  logic [WIDTH-1:0] n_i,
  input  logic             set_flags_i,
  input  logic             shift_carry_i,
  output logic [WIDTH-1:0] result_o,
  output logic             wr_en_o,
  output logic [3:0]       flags_o,
  output logic [3:0]       flags_next_o
);

  alu_op_e          op;
  logic [WIDTH-1:0] res;
  logic             is_arith;
  logic             carry;
  logic             ovf;
  flags_t           flags_q;
  flags_t           flags_d;
  logic             upd;

  assign op = alu_op_e'(op_i);

  dp_alu_core #(.WIDTH(WIDTH)) u_core (
    .op       (op),
    .rn       (rn_i),
    .n        (n_i),
    .c_in     (flags_q.c),
    .res      (res),
    .is_arith (is_arith),
    .carry    (carry),
    .ovf      (ovf)
  );

  dp_alu_flags #(.WIDTH(WIDTH)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .set_flags (set_flags_i),
    .shift_c   (shift_carry_i),
    .res       (res),
    .is_arith  (is_arith),
    .carry     (carry),
    .ovf       (ovf),
    .flags_q   (flags_q),
    .flags_d   (flags_d),
    .upd       (upd)
  );

  assign result_o     = res;
  assign wr_en_o      = !op_is_cmp(op);
  assign flags_o      = flags_q;
  assign flags_next_o = flags_d;

  // R6
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i[3:2] == 2'b10) |-> (!wr_en_o && upd));

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (flags_o == 4'b0000));

endmodule

// File: tb/dp_alu_bench.sv
module dp_alu_bench;

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] rn;
    logic [31:0] n;
    logic        s;
    logic        sc;
    logic [31:0] res;
    logic        wr;
    logic [3:0]  fl;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{4'd4,  32'd5,         32'd7,         1'b1, 1'b0, 32'd12,        1'b1, 4'b0000},
    '{4'd4,  32'hFFFFFFFF,  32'd1,         1'b1, 1'b0, 32'd0,         1'b1, 4'b0110},
    '{4'd5,  32'd3,         32'd4,         1'b0, 1'b0, 32'd8,         1'b1, 4'b0110},
    '{4'd6,  32'd10,        32'd3,         1'b1, 1'b0, 32'd7,         1'b1, 4'b0010},
    '{4'd2,  32'd3,         32'd5,         1'b1, 1'b0, 32'hFFFFFFFE,  1'b1, 4'b1000},
    '{4'd7,  32'd2,         32'd9,         1'b0, 1'b0, 32'd6,         1'b1, 4'b1000},
    '{4'd6,  32'd10,        32'd3,         1'b0, 1'b0, 32'd6,         1'b1, 4'b1000},
    '{4'd3,  32'd2,         32'd9,         1'b1, 1'b0, 32'd7,         1'b1, 4'b0010},
    '{4'd4,  32'h7FFFFFFF,  32'd1,         1'b1, 1'b0, 32'h80000000,  1'b1, 4'b1001},
    '{4'd0,  32'hF0F0F0F0,  32'h0FF00FF0,  1'b1, 1'b1, 32'h00F000F0,  1'b1, 4'b0011},
    '{4'd1,  32'hFFFF0000,  32'h0F0F0F0F,  1'b0, 1'b0, 32'hF0F00F0F,  1'b1, 4'b0011},
    '{4'd12, 32'h12000000,  32'h00000034,  1'b0, 1'b0, 32'h12000034,  1'b1, 4'b0011},
    '{4'd14, 32'hFFFFFFFF,  32'h000000FF,  1'b1, 1'b0, 32'hFFFFFF00,  1'b1, 4'b1001},
    '{4'd13, 32'hDEADBEEF,  32'h00000000,  1'b1, 1'b1, 32'h00000000,  1'b1, 4'b0111},
    '{4'd15, 32'h12345678,  32'h0000FFFF,  1'b1, 1'b0, 32'hFFFF0000,  1'b1, 4'b1001},
    '{4'd10, 32'd5,         32'd5,         1'b0, 1'b0, 32'd0,         1'b0, 4'b0110},
    '{4'd11, 32'h7FFFFFFF,  32'd1,         1'b0, 1'b0, 32'h80000000,  1'b0, 4'b1001},
    '{4'd8,  32'h0000000F,  32'h000000F0,  1'b0, 1'b1, 32'd0,         1'b0, 4'b0111},
    '{4'd9,  32'h80000000,  32'h00000000,  1'b0, 1'b0, 32'h80000000,  1'b0, 4'b1001},
    '{4'd2,  32'd0,         32'd1,         1'b0, 1'b0, 32'hFFFFFFFF,  1'b1, 4'b1001}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  op_i;
  logic [31:0] rn_i;
  logic [31:0] n_i;
  logic        set_flags_i;
  logic        shift_carry_i;
  logic [31:0] result_o;
  logic        wr_en_o;
  logic [3:0]  flags_o;
  logic [3:0]  flags_next_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  dp_alu u_dp_alu (
    .clk           (clk),
    .rst_n         (rst_n),
    .op_i          (op_i),
    .rn_i          (rn_i),
    .n_i           (n_i),
    .set_flags_i   (set_flags_i),
    .shift_carry_i (shift_carry_i),
    .result_o      (result_o),
    .wr_en_o       (wr_en_o),
    .flags_o       (flags_o),
    .flags_next_o  (flags_next_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd4, 4'd5:                   return "R1";
      4'd2, 4'd6:                   return "R2";
      4'd3, 4'd7:                   return "R3";
      4'd0, 4'd1, 4'd12, 4'd14:     return "R4";
      4'd13, 4'd15:                 return "R5";
      default:                      return "R6";
    endcase
  endfunction

  task automatic drive(input logic [3:0] op, input logic [31:0] rn, input logic [31:0] n,
                       input logic s, input logic sc);
    @(negedge clk);
    op_i = op; rn_i = rn; n_i = n; set_flags_i = s; shift_carry_i = sc;
    #1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    op_i = 4'd0; rn_i = '0; n_i = '0; set_flags_i = 1'b0; shift_carry_i = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 reset flags", {28'd0, flags_o}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].op, VECS[i].rn, VECS[i].n, VECS[i].s, VECS[i].sc);
      chk({tag_of(VECS[i].op), " result"}, result_o, VECS[i].res);
      chk("R6 write enable", {31'd0, wr_en_o}, {31'd0, VECS[i].wr});
      chk("R7 next flags R8 R9 R10", {28'd0, flags_next_o}, {28'd0, VECS[i].fl});
      @(posedge clk);
      #1;
      chk("R7 stored flags R8 R9 R10", {28'd0, flags_o}, {28'd0, VECS[i].fl});
    end

    // R5: MOV and MVN ignore rn
    drive(4'd13, 32'h00000000, 32'h0000ABCD, 1'b0, 1'b0);
    chk("R5 mov rn zero", result_o, 32'h0000ABCD);
    drive(4'd13, 32'hFFFFFFFF, 32'h0000ABCD, 1'b0, 1'b0);
    chk("R5 mov rn ones", result_o, 32'h0000ABCD);
    drive(4'd15, 32'h5A5A5A5A, 32'h0000ABCD, 1'b0, 1'b0);
    chk("R5 mvn", result_o, 32'hFFFF5432);

    // R7: non-compare with S clear leaves flags alone (flags were 1001)
    drive(4'd4, 32'd0, 32'd0, 1'b0, 1'b1);
    chk("R7 next equals held", {28'd0, flags_next_o}, 32'h9);
    @(posedge clk);
    #1;
    chk("R7 held after edge", {28'd0, flags_o}, 32'h9);

    // R11: reset mid-run clears the flags
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R11 async clear", {28'd0, flags_o}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: ADC after reset uses carry 0
    drive(4'd5, 32'd3, 32'd4, 1'b0, 1'b0);
    chk("R1 adc carry clear", result_o, 32'd7);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule